// File: doc/BRIEF.md
# RTC Alarm Comparator and Interrupt

This block watches the calendar time produced by a timekeeping core and raises an interrupt when it reaches a programmed alarm instant. Six BCD alarm fields are compared with the current time: seconds, minutes, hours, day of month, month and two-digit year. The comparison takes place only on the single-cycle pulse that marks each seconds update. The weekday does not take part in the match.

A match sets a sticky alarm flag, whether or not the alarm enable is set. The flag stays set until software writes a one to it. The interrupt line is a registered level equal to the flag AND the enable bit. Software can therefore turn the enable off, rewrite the alarm fields without causing a spurious interrupt, and turn the enable back on. All register access uses a simple synchronous bus with address, write data, write enable and registered read data.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, all alarm fields, the enable bit, the alarm flag, `alarm_irq` and `bus_rdata` are zero.
- R2: A write to address i (0 to N_FIELDS-1) stores `bus_wdata` in alarm field i. The field order is seconds, minutes, hours, day, month, year. Field i of `now_time` is bits [8i+7:8i]. `bus_rdata` is registered: it shows the addressed register as it was before the clock edge that samples the address.
- R3: The flag sets only on a clock edge where `sec_tick` is high and all six alarm fields equal the matching fields of `now_time`. When `sec_tick` is low, an equal time has no effect.
- R4: If any single field differs, a tick leaves the flag unchanged.
- R5: A match sets the flag even while the enable bit is zero, and `alarm_irq` stays low during that time.
- R6: `alarm_irq` equals flag AND enable after every clock edge. It rises and falls on the edge after the cause appears.
- R7: Writing to address N_FIELDS+1 with bit 0 at one clears the flag. Writing that address with bit 0 at zero has no effect. The flag reads back as bit 0 at that address.
- R8: When a match and a clear occur on the same edge, the flag ends up set.
- R9: Bit 0 at address N_FIELDS is the alarm enable. It can be written and read back.
- R10: Once set, the flag stays set through any number of later non-matching ticks, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | FIELD_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | FIELD_W | Registered read data |
| sec_tick | input | 1 | One-cycle seconds-update pulse |
| now_time | input | N_FIELDS*FIELD_W | Current BCD time, seconds in the low byte |
| alarm_irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default parameters: eight-bit fields, six fields and a three-bit address. With these values every address slot, including control and status, is decoded, and each of the six fields can be made to mismatch in turn. A behavioural model runs next to the design on every cycle. Directed sequences cover ticks with the enable off, writes of zero and one to the status address, and a clear that coincides with a matching tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  typedef enum logic [1:0] {
    SEL_FIELD,
    SEL_CTRL,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int N_FIELDS = 6,
  parameter int FIELD_W  = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [FIELD_W-1:0]          wdata_i,
  input  logic                        we_i,
  input  logic                        flag_i,
  output logic [N_FIELDS*FIELD_W-1:0] alarm_o,
  output logic                        en_q_o,
  output logic                        en_d_o,
  output logic                        clr_o,
  output logic [FIELD_W-1:0]          rdata_o
);
  localparam int CTRL_ADDR = N_FIELDS;
  localparam int STAT_ADDR = N_FIELDS + 1;

  reg_sel_e           sel;
  logic [FIELD_W-1:0] rd_mux;
  logic [FIELD_W-1:0] rd_field;

  always_comb begin
    if (int'(addr_i) < N_FIELDS)        sel = SEL_FIELD;
    else if (int'(addr_i) == CTRL_ADDR) sel = SEL_CTRL;
    else if (int'(addr_i) == STAT_ADDR) sel = SEL_STAT;
    else                                sel = SEL_NONE;
  end

  genvar g;
  generate
    for (g = 0; g < N_FIELDS; g++) begin : g_field
      always_ff @(posedge clk) begin
        if (rst)
          alarm_o[g*FIELD_W +: FIELD_W] <= '0;
        else if (we_i && sel == SEL_FIELD && int'(addr_i) == g)
          alarm_o[g*FIELD_W +: FIELD_W] <= wdata_i;
      end
    end
  endgenerate

  assign en_d_o = (we_i && sel == SEL_CTRL) ? wdata_i[0] : en_q_o;
  assign clr_o  = we_i && sel == SEL_STAT && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) en_q_o <= 1'b0;
    else     en_q_o <= en_d_o;
  end

  always_comb begin
    rd_field = '0;
    for (int i = 0; i < N_FIELDS; i++)
      if (int'(addr_i) == i) rd_field = alarm_o[i*FIELD_W +: FIELD_W];
  end

  always_comb begin
    case (sel)
      SEL_FIELD: rd_mux = rd_field;
      SEL_CTRL:  rd_mux = {{(FIELD_W-1){1'b0}}, en_q_o};
      SEL_STAT:  rd_mux = {{(FIELD_W-1){1'b0}}, flag_i};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel == SEL_CTRL) |=> (en_q_o == $past(wdata_i[0])));

  assert_field0_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == '0) |=> (alarm_o[FIELD_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int N_FIELDS = 6,
  parameter int FIELD_W  = 8
) (
  input  logic [N_FIELDS*FIELD_W-1:0] alarm_i,
  input  logic [N_FIELDS*FIELD_W-1:0] now_i,
  input  logic                        tick_i,
  output logic                        hit_o
);
  logic [N_FIELDS-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < N_FIELDS; g++) begin : g_cmp
      assign eq[g] = alarm_i[g*FIELD_W +: FIELD_W] == now_i[g*FIELD_W +: FIELD_W];
    end
  endgenerate

  assign hit_o = tick_i && (&eq);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic clr_i,
  input  logic en_d_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_d;

  always_comb begin
    if (hit_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d & en_d_i;
    end
  end

  assert_match_sets_R3: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_o);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !hit_i) |=> !flag_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit_i) |=> !flag_o);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && hit_i) |=> flag_o);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int N_FIELDS = 6,
  parameter int FIELD_W  = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [FIELD_W-1:0]          bus_wdata,
  input  logic                        bus_we,
  output logic [FIELD_W-1:0]          bus_rdata,
  input  logic                        sec_tick,
  input  logic [N_FIELDS*FIELD_W-1:0] now_time,
  output logic                        alarm_irq
);
  localparam int TIME_W = N_FIELDS * FIELD_W;

  logic [TIME_W-1:0] alarm;
  logic              en_q, en_d, clr, flag, hit;

  rtc_alarm_regs #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wdata_i(bus_wdata), .we_i(bus_we),
    .flag_i(flag), .alarm_o(alarm), .en_q_o(en_q), .en_d_o(en_d), .clr_o(clr),
    .rdata_o(bus_rdata)
  );

  rtc_alarm_match #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_match (
    .alarm_i(alarm), .now_i(now_time), .tick_i(sec_tick), .hit_o(hit)
  );

  rtc_alarm_flag u_flag (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(clr), .en_d_i(en_d),
    .flag_o(flag), .irq_o(alarm_irq)
  );

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    alarm_irq == (flag && en_q));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !alarm_irq);
endmodule

// File: tb/test_rtc_alarm_unit.sv
module test_rtc_alarm_unit;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int AW = 3;
  localparam int CTRL = NF;
  localparam int STAT = NF + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [FW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [FW-1:0] bus_rdata;
  logic          sec_tick = 1'b0;
  logic [NF*FW-1:0] now_time = '0;
  logic          alarm_irq;

  always #4 clk = ~clk;

  rtc_alarm_unit #(.N_FIELDS(NF), .FIELD_W(FW), .ADDR_W(AW)) i_rtc_alarm_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .sec_tick(sec_tick), .now_time(now_time), .alarm_irq(alarm_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [FW-1:0] m_al [NF];
  logic          m_en = 0, m_st = 0, m_irq = 0;
  logic [FW-1:0] m_rd = '0;
  logic [FW-1:0] al_set [NF] = '{8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h24};

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] m_read(int a);
    if (a < NF)    return m_al[a];
    if (a == CTRL) return {{(FW-1){1'b0}}, m_en};
    if (a == STAT) return {{(FW-1){1'b0}}, m_st};
    return '0;
  endfunction

  task automatic cycle();
    logic          hit;
    logic          n_st, n_en;
    logic [FW-1:0] n_rd;
    logic [FW-1:0] n_al [NF];
    hit = sec_tick;
    for (int i = 0; i < NF; i++)
      if (m_al[i] != now_time[i*FW +: FW]) hit = 0;
    n_rd = m_read(int'(bus_addr));
    n_en = (bus_we && int'(bus_addr) == CTRL) ? bus_wdata[0] : m_en;
    if (hit) n_st = 1;
    else if (bus_we && int'(bus_addr) == STAT && bus_wdata[0]) n_st = 0;
    else n_st = m_st;
    for (int i = 0; i < NF; i++)
      n_al[i] = (bus_we && int'(bus_addr) == i) ? bus_wdata : m_al[i];
    if (rst) begin
      n_st = 0; n_en = 0; n_rd = '0;
      for (int i = 0; i < NF; i++) n_al[i] = '0;
    end
    @(posedge clk); #1;
    m_st = n_st; m_en = n_en; m_rd = n_rd; m_irq = n_st & n_en;
    for (int i = 0; i < NF; i++) m_al[i] = n_al[i];
    chk({cur_req, " irq"}, {7'b0, alarm_irq}, {7'b0, m_irq});
    chk({cur_req, " rdata"}, bus_rdata, m_rd);
  endtask

  task automatic wr(int a, logic [FW-1:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1; cycle(); bus_we = 0;
  endtask

  task automatic rd(int a);
    bus_addr = AW'(a); cycle();
  endtask

  function automatic logic [NF*FW-1:0] alarm_time();
    logic [NF*FW-1:0] t;
    for (int i = 0; i < NF; i++) t[i*FW +: FW] = al_set[i];
    return t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NF; i++) m_al[i] = '0;
    cur_req = "R1";
    cycle(); cycle();
    rst = 0;
    cycle();
    chk("R1 irq after reset", {7'b0, alarm_irq}, 8'h00);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    rd(STAT); chk("R1 flag after reset", bus_rdata, 8'h00);

    cur_req = "R2";
    for (int i = 0; i < NF; i++) wr(i, al_set[i]);
    for (int i = 0; i < NF; i++) begin
      rd(i); chk("R2 field readback", bus_rdata, al_set[i]);
    end

    cur_req = "R3";
    now_time = alarm_time();
    sec_tick = 0;
    repeat (4) cycle();
    rd(STAT); chk("R3 no tick no set", bus_rdata, 8'h00);

    cur_req = "R4";
    for (int f = 0; f < NF; f++) begin
      now_time = alarm_time();
      now_time[f*FW] = ~now_time[f*FW];
      sec_tick = 1; cycle(); sec_tick = 0;
      rd(STAT); chk("R4 one field differs", bus_rdata, 8'h00);
    end

    cur_req = "R5";
    now_time = alarm_time();
    sec_tick = 1; cycle(); sec_tick = 0;
    chk("R5 irq held low while disabled", {7'b0, alarm_irq}, 8'h00);
    rd(STAT); chk("R5 flag set while disabled", bus_rdata, 8'h01);

    cur_req = "R9";
    wr(CTRL, 8'h01);
    chk("R6 irq rises after enable", {7'b0, alarm_irq}, 8'h01);
    rd(CTRL); chk("R9 enable readback", bus_rdata, 8'h01);

    cur_req = "R10";
    now_time[FW +: FW] = 8'h59;
    for (int k = 0; k < 5; k++) begin
      sec_tick = 1; cycle(); sec_tick = 0; cycle();
    end
    rd(STAT); chk("R10 flag sticky", bus_rdata, 8'h01);

    cur_req = "R7";
    wr(STAT, 8'h00);
    rd(STAT); chk("R7 write zero no effect", bus_rdata, 8'h01);
    chk("R7 irq kept after zero write", {7'b0, alarm_irq}, 8'h01);
    wr(STAT, 8'hFE);
    rd(STAT); chk("R7 bit0 zero no effect", bus_rdata, 8'h01);
    wr(STAT, 8'h01);
    chk("R7 irq falls after clear", {7'b0, alarm_irq}, 8'h00);
    rd(STAT); chk("R7 flag cleared", bus_rdata, 8'h00);

    cur_req = "R8";
    now_time = alarm_time();
    sec_tick = 1;
    bus_addr = AW'(STAT); bus_wdata = 8'h01; bus_we = 1;
    cycle();
    bus_we = 0; sec_tick = 0;
    rd(STAT); chk("R8 set wins over clear", bus_rdata, 8'h01);
    chk("R8 irq set", {7'b0, alarm_irq}, 8'h01);

    cur_req = "R6";
    wr(CTRL, 8'h00);
    chk("R6 irq falls when disabled", {7'b0, alarm_irq}, 8'h00);
    wr(STAT, 8'h01);
    wr(0, 8'h00); wr(1, 8'h42);
    now_time = '0; now_time[FW +: FW] = 8'h42;
    now_time[2*FW +: FW] = al_set[2];
    sec_tick = 1; cycle(); sec_tick = 0;
    chk("R6 quiet during partial rewrite", {7'b0, alarm_irq}, 8'h00);
    for (int i = 2; i < NF; i++) wr(i, al_set[i]);
    now_time = alarm_time();
    now_time[7:0] = 8'h00; now_time[FW +: FW] = 8'h42;
    sec_tick = 1; cycle(); sec_tick = 0;
    chk("R6 irq low with flag but enable off", {7'b0, alarm_irq}, 8'h00);
    wr(CTRL, 8'h01);
    chk("R6 irq on after enable", {7'b0, alarm_irq}, 8'h01);

    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin
      sec_tick = k[0];
      now_time[7:0] = k[2] ? 8'h00 : 8'h01;
      bus_addr = AW'(k % 8);
      bus_we = (k % 5 == 0) && (k % 8 == STAT);
      bus_wdata = 8'h01;
      cycle();
    end
    bus_we = 0; sec_tick = 0;
    cycle();
    finish_run();
  end
endmodule